// File: doc/BRIEF.md
# Compressed Page Block Address Translator

This block turns a logical block number inside a page into the physical block address where that block is stored, for pages whose storage packs some neighbouring block pairs into a single block slot. The page-table entry supplies three things: the base block address of the page, a size-class flag (full page or half page), and a vector with one bit per even/odd block pair. A set bit means the pair shares one slot. A clear bit means the pair uses two slots. Every stored unit starts on a block boundary, so the physical offset of a block is a running count over the pair bits below it.

The translator takes one query at a time. A request pulse on `start_i` captures the inputs. The pair vector is then walked a few pairs per cycle with a parameterised lane count. After a fixed number of cycles, the physical block address, a "lives in a compressed slot" flag and two error flags come out together with a one-cycle `done_o` pulse. These results stay on the outputs until the next query completes.

Top module: `pg_blk_xlate`

## Requirements
- R1: While `rst_ni` is low, and after it rises until the first query completes, `done_o`, `busy_o`, `in_pair_o`, `range_err_o` and `align_err_o` are 0 and `phys_blk_o` is 0.
- R2: For logical block b, `phys_blk_o` = `base_blk_i` + offset. The offset is the sum, over every pair p with p < floor(b/2), of 1 when vector bit p is 1 and 2 when it is 0. Another 1 is added when b is odd and bit floor(b/2) is 0.
- R3: When the pair bit of block b (vector bit floor(b/2)) is 1, `in_pair_o` is 1 and blocks 2p and 2p+1 give the same `phys_blk_o`.
- R4: When the pair bit of block b is 0, `in_pair_o` is 0 and the odd block of the pair gives the address of the even block plus 1.
- R5: Vector bits at index floor(b/2)+1 and above have no effect on the result for block b.
- R6: A request is accepted when `start_i` is 1 while `busy_o` is 0. `busy_o` is 1 from the next cycle until `done_o` rises. `done_o` is a single-cycle pulse, visible PAIRS/LANES+1 clock edges after the accepting edge (9 with defaults).
- R7: `start_i` while `busy_o` is 1 is ignored. The completed result belongs to the inputs captured at acceptance.
- R8: `range_err_o` is 1 when the offset is at or above the page size in blocks. That size is BLKS when `half_page_i` is 0 and BLKS/2 when it is 1. A full page never flags it.
- R9: `align_err_o` is 1 when `base_blk_i` is not a multiple of the page size in blocks selected by `half_page_i` (64 full, 32 half with defaults).
- R10: Between two `done_o` pulses, `phys_blk_o` and the flags hold their values, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Query request, taken when idle |
| half_page_i | input | 1 | Page size class: 1 = half page, 0 = full page |
| base_blk_i | input | ADDR_W | Physical block address of the page base |
| pair_vec_i | input | BLKS/2 | Per-pair compression bits, bit p covers blocks 2p and 2p+1 |
| lblk_i | input | log2(BLKS) | Logical block number within the page |
| busy_o | output | 1 | Query in progress |
| done_o | output | 1 | One-cycle pulse when results update |
| phys_blk_o | output | ADDR_W | Physical block address |
| in_pair_o | output | 1 | Target block is stored in a compressed pair slot |
| range_err_o | output | 1 | Offset falls outside the selected page size |
| align_err_o | output | 1 | Base is not aligned to the selected page size |

## Verification
The assertions assume that `start_i` is a clean synchronous level and that `half_page_i` and `base_blk_i` are valid in the cycle a request is accepted. The checker records the base and size class only at that point. They also assume that the base plus the largest offset does not wrap the address width, because the bound check subtracts the recorded base from the result. The stimulus keeps every base far below the top of the address space. It holds all inputs steady across the accepting edge and changes them only on falling edges, including the deliberate changes made while a query is running.

// File: rtl/pg_blk_xlate_pkg.sv
package pg_blk_xlate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } walk_st_e;

  // slots used by one pair: shared slot or two raw slots
  function automatic logic [1:0] pair_slots(input logic packed_bit);
    return packed_bit ? 2'd1 : 2'd2;
  endfunction

endpackage

// File: rtl/pg_chunk_sum.sv
module pg_chunk_sum
  import pg_blk_xlate_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned PAIR_W = 5,
  localparam int unsigned SUM_W = $clog2(2 * LANES + 1)
) (
  input  logic [LANES-1:0]  bits_i,
  input  logic [PAIR_W-1:0] chunk_base_i,
  input  logic [PAIR_W-1:0] tgt_pair_i,
  output logic [SUM_W-1:0]  sum_o
);

  logic [LANES-1:0] lane_take;
  logic [1:0]       lane_cost [LANES];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [PAIR_W-1:0] lane_idx;
    assign lane_idx     = chunk_base_i + PAIR_W'(j);
    assign lane_take[j] = lane_idx < tgt_pair_i;
    assign lane_cost[j] = pair_slots(bits_i[j]);
  end

  always_comb begin
    sum_o = '0;
    for (int j = 0; j < LANES; j++) begin
      if (lane_take[j]) sum_o = sum_o + SUM_W'(lane_cost[j]);
    end
  end

endmodule

// File: rtl/pg_walker.sv
module pg_walker
  import pg_blk_xlate_pkg::*;
#(
  parameter int unsigned BLKS   = 64,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LANES  = 4,
  localparam int unsigned PAIRS  = BLKS / 2,
  localparam int unsigned LBLK_W = $clog2(BLKS),
  localparam int unsigned PAIR_W = $clog2(PAIRS),
  localparam int unsigned OFF_W  = LBLK_W + 1,
  localparam int unsigned NSTEP  = PAIRS / LANES,
  localparam int unsigned STEP_W = $clog2(NSTEP),
  localparam int unsigned LSH    = $clog2(LANES),
  localparam int unsigned SUM_W  = $clog2(2 * LANES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              half_page_i,
  input  logic [ADDR_W-1:0] base_blk_i,
  input  logic [PAIRS-1:0]  pair_vec_i,
  input  logic [LBLK_W-1:0] lblk_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic [OFF_W-1:0]  acc_o,
  output logic              half_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [PAIRS-1:0]  vec_o,
  output logic [LBLK_W-1:0] lblk_o
);

  walk_st_e          st_q;
  logic [STEP_W-1:0] step_q;
  logic [OFF_W-1:0]  acc_q;
  logic              half_q;
  logic [ADDR_W-1:0] base_q;
  logic [PAIRS-1:0]  vec_q;
  logic [LBLK_W-1:0] lblk_q;

  logic [PAIR_W-1:0] chunk_base;
  logic [PAIR_W-1:0] tgt_pair;
  logic [LANES-1:0]  chunk_bits;
  logic [SUM_W-1:0]  chunk_sum;
  logic              accept;

  assign accept     = start_i && (st_q == ST_IDLE);
  assign chunk_base = {step_q, {LSH{1'b0}}};
  assign tgt_pair   = lblk_q[LBLK_W-1:1];
  assign chunk_bits = vec_q[chunk_base +: LANES];

  pg_chunk_sum #(
    .LANES (LANES),
    .PAIR_W(PAIR_W)
  ) u_sum (
    .bits_i      (chunk_bits),
    .chunk_base_i(chunk_base),
    .tgt_pair_i  (tgt_pair),
    .sum_o       (chunk_sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      acc_q  <= '0;
      half_q <= 1'b0;
      base_q <= '0;
      vec_q  <= '0;
      lblk_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_q   <= ST_RUN;
            step_q <= '0;
            acc_q  <= '0;
            half_q <= half_page_i;
            base_q <= base_blk_i;
            vec_q  <= pair_vec_i;
            lblk_q <= lblk_i;
          end
        end
        ST_RUN: begin
          acc_q  <= acc_q + OFF_W'(chunk_sum);
          step_q <= step_q + 1'b1;
          if (step_q == STEP_W'(NSTEP - 1)) st_q <= ST_FIN;
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = st_q != ST_IDLE;
  assign fin_o  = st_q == ST_FIN;
  assign acc_o  = acc_q;
  assign half_o = half_q;
  assign base_o = base_q;
  assign vec_o  = vec_q;
  assign lblk_o = lblk_q;

endmodule

// File: rtl/pg_compose.sv
module pg_compose #(
  parameter int unsigned BLKS   = 64,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned PAIRS  = BLKS / 2,
  localparam int unsigned LBLK_W = $clog2(BLKS),
  localparam int unsigned OFF_W  = LBLK_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fin_i,
  input  logic [OFF_W-1:0]  acc_i,
  input  logic              half_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [PAIRS-1:0]  vec_i,
  input  logic [LBLK_W-1:0] lblk_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] phys_blk_o,
  output logic              in_pair_o,
  output logic              range_err_o,
  output logic              align_err_o
);

  localparam logic [ADDR_W-1:0] FULL_MASK = ADDR_W'(BLKS - 1);
  localparam logic [ADDR_W-1:0] HALF_MASK = ADDR_W'(BLKS / 2 - 1);
  localparam logic [OFF_W-1:0]  FULL_LIM  = OFF_W'(BLKS);
  localparam logic [OFF_W-1:0]  HALF_LIM  = OFF_W'(BLKS / 2);

  logic             own_bit;
  logic [OFF_W-1:0] offset;
  logic [OFF_W-1:0] lim;
  logic             mis;

  assign own_bit = vec_i[lblk_i[LBLK_W-1:1]];
  assign offset  = acc_i + OFF_W'(lblk_i[0] & ~own_bit);
  assign lim     = half_i ? HALF_LIM : FULL_LIM;
  assign mis     = |(base_i & (half_i ? HALF_MASK : FULL_MASK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      phys_blk_o  <= '0;
      in_pair_o   <= 1'b0;
      range_err_o <= 1'b0;
      align_err_o <= 1'b0;
    end else begin
      done_o <= fin_i;
      if (fin_i) begin
        phys_blk_o  <= base_i + ADDR_W'(offset);
        in_pair_o   <= own_bit;
        range_err_o <= offset >= lim;
        align_err_o <= mis;
      end
    end
  end

endmodule

// File: rtl/pg_blk_xlate.sv
module pg_blk_xlate
  import pg_blk_xlate_pkg::*;
#(
  parameter int unsigned BLKS   = 64,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LANES  = 4,
  localparam int unsigned PAIRS  = BLKS / 2,
  localparam int unsigned LBLK_W = $clog2(BLKS),
  localparam int unsigned OFF_W  = LBLK_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              half_page_i,
  input  logic [ADDR_W-1:0] base_blk_i,
  input  logic [PAIRS-1:0]  pair_vec_i,
  input  logic [LBLK_W-1:0] lblk_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] phys_blk_o,
  output logic              in_pair_o,
  output logic              range_err_o,
  output logic              align_err_o
);

  logic              fin;
  logic [OFF_W-1:0]  acc;
  logic              half_q;
  logic [ADDR_W-1:0] base_q;
  logic [PAIRS-1:0]  vec_q;
  logic [LBLK_W-1:0] lblk_q;

  pg_walker #(
    .BLKS  (BLKS),
    .ADDR_W(ADDR_W),
    .LANES (LANES)
  ) u_walk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .half_page_i(half_page_i),
    .base_blk_i (base_blk_i),
    .pair_vec_i (pair_vec_i),
    .lblk_i     (lblk_i),
    .busy_o     (busy_o),
    .fin_o      (fin),
    .acc_o      (acc),
    .half_o     (half_q),
    .base_o     (base_q),
    .vec_o      (vec_q),
    .lblk_o     (lblk_q)
  );

  pg_compose #(
    .BLKS  (BLKS),
    .ADDR_W(ADDR_W)
  ) u_comp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fin_i      (fin),
    .acc_i      (acc),
    .half_i     (half_q),
    .base_i     (base_q),
    .vec_i      (vec_q),
    .lblk_i     (lblk_q),
    .done_o     (done_o),
    .phys_blk_o (phys_blk_o),
    .in_pair_o  (in_pair_o),
    .range_err_o(range_err_o),
    .align_err_o(align_err_o)
  );

endmodule

// File: rtl/pg_blk_xlate_chk.sv
module pg_blk_xlate_chk #(
  parameter int unsigned BLKS   = 64,
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              half_page_i,
  input logic [ADDR_W-1:0] base_blk_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] phys_blk_o,
  input logic              range_err_o,
  input logic              align_err_o
);

  logic              half_r;
  logic [ADDR_W-1:0] base_r;
  logic [ADDR_W-1:0] mask_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_r <= 1'b0;
      base_r <= '0;
    end else if (start_i && !busy_o) begin
      half_r <= half_page_i;
      base_r <= base_blk_i;
    end
  end

  assign mask_r = half_r ? ADDR_W'(BLKS / 2 - 1) : ADDR_W'(BLKS - 1);

  AST_BOUND_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (phys_blk_o - base_r) < ADDR_W'(BLKS)); // R2
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R6
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o)); // R7
  AST_FULL_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !half_r) |-> !range_err_o); // R8
  AST_ALIGN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (align_err_o == |(base_r & mask_r))); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(phys_blk_o) && $stable(range_err_o))); // R10

endmodule

bind pg_blk_xlate pg_blk_xlate_chk #(
  .BLKS  (BLKS),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .half_page_i(half_page_i),
  .base_blk_i (base_blk_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .phys_blk_o (phys_blk_o),
  .range_err_o(range_err_o),
  .align_err_o(align_err_o)
);

// File: tb/pg_blk_xlate_tb.sv
module pg_blk_xlate_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BLKS       = 64;
  localparam int ADDR_W     = 32;
  localparam int LANES      = 4;
  localparam int LAT        = (BLKS / 2) / LANES + 1;
  localparam int NVEC       = 13;

  typedef struct packed {
    logic        half;
    logic [31:0] base;
    logic [31:0] vec;
    logic [5:0]  lblk;
    logic [31:0] phys;
    logic        pair;
    logic        rerr;
    logic        aerr;
  } vec_t;

  // {half, base, pair vector, lblk, phys, in_pair, range_err, align_err}
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 32'h1000, 32'h0000_0000, 6'd0,  32'h1000, 1'b0, 1'b0, 1'b0}, // R2 raw
    '{1'b0, 32'h1000, 32'h0000_0000, 6'd63, 32'h103F, 1'b0, 1'b0, 1'b0}, // R2 R4
    '{1'b0, 32'h1000, 32'hFFFF_FFFF, 6'd63, 32'h101F, 1'b1, 1'b0, 1'b0}, // R3
    '{1'b0, 32'h1000, 32'hFFFF_FFFF, 6'd62, 32'h101F, 1'b1, 1'b0, 1'b0}, // R3
    '{1'b0, 32'h1000, 32'h0000_0005, 6'd7,  32'h1005, 1'b0, 1'b0, 1'b0}, // R2 mixed
    '{1'b0, 32'h1000, 32'h0000_0005, 6'd5,  32'h1003, 1'b1, 1'b0, 1'b0}, // R3 mixed
    '{1'b0, 32'h1000, 32'hFFFF_FF05, 6'd7,  32'h1005, 1'b0, 1'b0, 1'b0}, // R5
    '{1'b1, 32'h2020, 32'hFFFF_FFFF, 6'd63, 32'h203F, 1'b1, 1'b0, 1'b0}, // R8 edge
    '{1'b1, 32'h2020, 32'hFFFF_FFFE, 6'd63, 32'h2040, 1'b1, 1'b1, 1'b0}, // R8 over
    '{1'b1, 32'h2020, 32'hFFFF_FFFE, 6'd61, 32'h203F, 1'b1, 1'b0, 1'b0}, // R8 last
    '{1'b0, 32'h1020, 32'h0000_0000, 6'd1,  32'h1021, 1'b0, 1'b0, 1'b1}, // R9 full
    '{1'b1, 32'h2010, 32'hFFFF_FFFF, 6'd0,  32'h2010, 1'b1, 1'b0, 1'b1}, // R9 half
    '{1'b0, 32'h1000, 32'h0000_0000, 6'd33, 32'h1021, 1'b0, 1'b0, 1'b0}  // R2 mid
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic              half_page_i = 1'b0;
  logic [ADDR_W-1:0] base_blk_i = '0;
  logic [BLKS/2-1:0] pair_vec_i = '0;
  logic [5:0]        lblk_i = '0;
  logic              busy_o, done_o, in_pair_o, range_err_o, align_err_o;
  logic [ADDR_W-1:0] phys_blk_o;

  int checks = 0;
  int errors = 0;
  int lat_seen;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  pg_blk_xlate #(
    .BLKS  (BLKS),
    .ADDR_W(ADDR_W),
    .LANES (LANES)
  ) u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .half_page_i(half_page_i),
    .base_blk_i (base_blk_i),
    .pair_vec_i (pair_vec_i),
    .lblk_i     (lblk_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .phys_blk_o (phys_blk_o),
    .in_pair_o  (in_pair_o),
    .range_err_o(range_err_o),
    .align_err_o(align_err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    half_page_i = v.half;
    base_blk_i  = v.base;
    pair_vec_i  = v.vec;
    lblk_i      = v.lblk;
  endtask

  // start at a negedge, return at the negedge where done_o is seen
  task automatic run_query(input vec_t v);
    drive(v);
    start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i  = 1'b0;
    lat_seen = 0;
    while (!done_o && lat_seen < 40) begin
      @(negedge clk_i);
      lat_seen++;
    end
  endtask

  task automatic check_result(input string req, input vec_t v);
    chk({req, " phys"},  phys_blk_o, v.phys);
    chk({req, " pair"},  32'(in_pair_o), 32'(v.pair));
    chk({req, " range"}, 32'(range_err_o), 32'(v.rerr));
    chk({req, " align"}, 32'(align_err_o), 32'(v.aerr));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    vec_t v;
    vec_t alt;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk("R1 done in reset", 32'(done_o), 0);
    chk("R1 busy in reset", 32'(busy_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R1 phys after reset", phys_blk_o, 0);
    chk("R1 flags after reset", {29'd0, in_pair_o, range_err_o, align_err_o}, 0);
    chk("R1 busy after reset", 32'(busy_o), 0);

    // table walk: R2 R3 R4 R5 R8 R9 and R6 latency
    for (int i = 0; i < NVEC; i++) begin
      v = VECS[i];
      run_query(v);
      chk("R6 latency", 32'(lat_seen), 32'(LAT));
      check_result($sformatf("R2 vec %0d", i), v);
      @(negedge clk_i);
      chk("R6 single pulse", 32'(done_o), 0);
    end

    // R6 busy window
    v = VECS[1];
    drive(v);
    start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R6 busy after accept", 32'(busy_o), 1);
    repeat (LAT - 1) @(negedge clk_i);
    chk("R6 busy before done", 32'(busy_o), 1);
    @(negedge clk_i);
    chk("R6 done at latency", 32'(done_o), 1);
    chk("R6 busy cleared at done", 32'(busy_o), 0);

    // R7 start while busy is ignored
    v   = VECS[4];
    alt = VECS[2];
    drive(v);
    start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    @(negedge clk_i);
    drive(alt);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat_seen = 2;
    while (!done_o && lat_seen < 40) begin
      @(negedge clk_i);
      lat_seen++;
    end
    chk("R7 latency unchanged", 32'(lat_seen), 32'(LAT));
    check_result("R7 first query kept", v);
    @(negedge clk_i);
    chk("R7 no second done", 32'(done_o), 0);
    chk("R7 not busy", 32'(busy_o), 0);

    // R10 outputs hold without a new query
    drive(VECS[8]);
    repeat (5) @(negedge clk_i);
    check_result("R10 hold", v);

    // R4 odd = even + 1 for clear pair bit, checked pairwise
    v = VECS[0];
    v.vec = 32'h0000_00F0;
    v.lblk = 6'd20;
    v.phys = 32'h1000 + 32'd16;  // pairs 0..3 cost 2, 4..7 cost 1, 8,9 cost 2 -> 8+4+4
    run_query(v);
    check_result("R4 even", v);
    v.lblk = 6'd21;
    v.phys = 32'h1000 + 32'd17;
    run_query(v);
    check_result("R4 odd", v);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule